// File: doc/BRIEF.md
# Converter Serial Port with End-of-Conversion Flag

This block is the digital serial port of a 16-bit successive-approximation converter. A rising edge on the conversion-start input launches a conversion of fixed length, counted in system clocks. At the end of that conversion the port captures a 16-bit sample from a parallel input, which stands in for the analog core. The host then clocks the serial clock. On its rising edges the port collects a 14-bit configuration word. On its falling edges it presents the captured result, most significant bit first.

The level of the conversion-start input at the moment a conversion ends picks how the data line behaves. If that input is low, the data line is pulled low at once, so a host watching it sees a high-to-low transition as an interrupt, provided the line was high before. If that input is high, the data line stays released until the host begins clocking. The line is released whenever the conversion-start input is high. It is also released once a result has been read completely, which takes a 17th falling edge. A partly read result leaves the last bit it presented on the line.

All three host inputs are asynchronous. They pass through two-flop synchronizers before the port detects their edges. The output enable is brought out as a separate port beside the data bit.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the data output is released (`sdo_en` low), `converting` is low and `cfg_out` holds all ones.
- R2: A rising edge on `cnv_in` while idle holds `converting` high for exactly CONV_CYCLES clocks. Rising edges on `cnv_in` during a conversion neither restart nor lengthen it.
- R3: At the end of a conversion the port captures `sample_in`. If `cnv_in` is low at that moment, the data output is driven with value 0. If `cnv_in` is high, the output remains released until the first falling edge of the serial clock.
- R4: The first 16 falling edges of `sck_in` after a conversion ends present the captured sample on `sdo_data`, with `sdo_en` high. Falling edge k (k = 1..16) presents sample bit 16-k, so bit 15 comes first and bit 0 comes last.
- R5: After the 16th falling edge the output keeps driving bit 0 for as long as no further falling edge arrives. The 17th falling edge releases the output, and any later falling edges leave it released.
- R6: While `cnv_in` is high, `sdo_en` is low, whatever the read state is.
- R7: A result that has not been read completely keeps its last presented bit on the output whenever `cnv_in` is low, including during the following conversion, until that conversion ends.
- R8: The first 14 rising edges of `sck_in` after a conversion ends shift `sdi_in` into the configuration, first bit into bit 13. `cfg_out` changes only at the 14th rising edge. Rising edges beyond the 14th, and any that come before the first conversion, leave it unchanged.
- R9: Serial clock edges that arrive while `converting` is high are ignored. They change neither `cfg_out` nor the data output, and they do not count toward the edges of the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_in | input | 1 | Conversion start and output release, asynchronous |
| sck_in | input | 1 | Host serial clock, asynchronous |
| sdi_in | input | 1 | Serial configuration data, asynchronous |
| sample_in | input | DATA_W | Parallel sample captured at end of conversion |
| sdo_data | output | 1 | Serial data bit |
| sdo_en | output | 1 | High when the serial data line is driven |
| cfg_out | output | CFG_W | Current configuration word |
| converting | output | 1 | High while a conversion is in progress |

## Verification
The bench runs a sweep of samples, including all zeros and all ones, through both end-of-conversion modes. It checks every bit position and the 17th-edge release. A port that counted falling edges off by one would shift the word or release the line early. The bench also stops a read after 16 edges and starts a new conversion with the last bit high, then confirms that this bit stays on the line during the conversion and drops to 0 at its end. A design that released an unfinished read, or did not force the busy low, would hide that transition. Serial clocks sent during a conversion must not consume bits from the next read and must not alter the configuration. Extra configuration clocks past the 14th must not corrupt the word. A retriggered conversion-start must not stretch the conversion window.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  localparam int unsigned DATA_W_DEF      = 16;
  localparam int unsigned CFG_W_DEF       = 14;
  localparam int unsigned CONV_CYCLES_DEF = 40;

  // input order inside the synchronizer vector
  localparam int unsigned IDX_CNV = 0;
  localparam int unsigned IDX_SCK = 1;
  localparam int unsigned IDX_SDI = 2;
  localparam int unsigned N_SYNC  = 3;
  localparam int unsigned N_EDGE  = 2;

  // serial output state
  typedef enum logic [1:0] {
    TX_QUIET = 2'd0,  // released, nothing pending
    TX_ARMED = 2'd1,  // released, result waiting for first falling edge
    TX_BUSY  = 2'd2,  // driving 0 after end of conversion
    TX_SHIFT = 2'd3   // driving result bits
  } tx_state_e;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned EDGE_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      async_in,
  output logic [N-1:0]      level,
  output logic [EDGE_N-1:0] prev
);

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      logic meta_q;
      logic stab_q;

      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= async_in[i];
          stab_q <= meta_q;
        end
      end

      assign level[i] = stab_q;

      // a third stage only for the inputs whose edges are needed
      if (i < EDGE_N) begin : g_edge
        logic dly_q;
        always_ff @(posedge clk) begin
          if (rst) dly_q <= 1'b0;
          else     dly_q <= stab_q;
        end
        assign prev[i] = dly_q;
      end
    end
  endgenerate

endmodule

// File: rtl/adc_sp_conv_timer.sv
module adc_sp_conv_timer #(
  parameter int unsigned CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic converting,
  output logic eoc
);

  localparam int unsigned CW = $clog2(CONV_CYCLES + 1);

  logic [CW-1:0] remain_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      remain_q <= '0;
    end else if (run_q) begin
      if (remain_q == '0) run_q    <= 1'b0;
      else                remain_q <= remain_q - 1'b1;
    end else if (start) begin
      run_q    <= 1'b1;
      remain_q <= CW'(CONV_CYCLES - 1);
    end
  end

  assign converting = run_q;
  assign eoc        = run_q && (remain_q == '0);

endmodule

// File: rtl/adc_sp_cfg_rx.sv
module adc_sp_cfg_rx #(
  parameter int unsigned          CFG_W     = 14,
  parameter logic [CFG_W-1:0]     CFG_RESET = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eoc,
  input  logic             converting,
  input  logic             sck_rise,
  input  logic             sdi,
  output logic [CFG_W-1:0] cfg_q
);

  localparam int unsigned RW = $clog2(CFG_W + 1);

  logic [RW-1:0]    taken_q;
  logic [CFG_W-1:0] shift_q;
  logic [CFG_W-1:0] shift_nx;

  assign shift_nx = {shift_q[CFG_W-2:0], sdi};

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_q <= RW'(CFG_W);
      shift_q <= '0;
      cfg_q   <= CFG_RESET;
    end else if (eoc) begin
      taken_q <= '0;
    end else if (sck_rise && !converting && (taken_q < RW'(CFG_W))) begin
      shift_q <= shift_nx;
      taken_q <= taken_q + 1'b1;
      if (taken_q == RW'(CFG_W - 1)) cfg_q <= shift_nx;
    end
  end

endmodule

// File: rtl/adc_sp_data_tx.sv
module adc_sp_data_tx
  import adc_sp_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eoc,
  input  logic              converting,
  input  logic              cnv_level,
  input  logic              sck_fall,
  input  logic [DATA_W-1:0] sample,
  output logic              sdo_data,
  output logic              sdo_en
);

  localparam int unsigned BW = $clog2(DATA_W + 1);

  tx_state_e        st_q;
  logic [DATA_W-1:0] shreg_q;
  logic [BW-1:0]    sent_q;
  logic             bit_q;
  logic             drive;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= TX_QUIET;
      shreg_q <= '0;
      sent_q  <= '0;
      bit_q   <= 1'b0;
    end else if (eoc) begin
      shreg_q <= sample;
      sent_q  <= '0;
      if (!cnv_level) begin
        st_q  <= TX_BUSY;
        bit_q <= 1'b0;
      end else begin
        st_q  <= TX_ARMED;
      end
    end else if (sck_fall && !converting) begin
      unique case (st_q)
        TX_BUSY, TX_ARMED: begin
          bit_q   <= shreg_q[DATA_W-1];
          shreg_q <= shreg_q << 1;
          sent_q  <= BW'(1);
          st_q    <= TX_SHIFT;
        end
        TX_SHIFT: begin
          if (sent_q == BW'(DATA_W)) begin
            st_q <= TX_QUIET;
          end else begin
            bit_q   <= shreg_q[DATA_W-1];
            shreg_q <= shreg_q << 1;
            sent_q  <= sent_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign drive = (st_q == TX_BUSY) || (st_q == TX_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sdo_en   <= 1'b0;
      sdo_data <= 1'b0;
    end else begin
      sdo_en   <= drive && !cnv_level;
      sdo_data <= bit_q;
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int unsigned      DATA_W      = DATA_W_DEF,
  parameter int unsigned      CFG_W       = CFG_W_DEF,
  parameter int unsigned      CONV_CYCLES = CONV_CYCLES_DEF,
  parameter logic [CFG_W-1:0] CFG_RESET   = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnv_in,
  input  logic              sck_in,
  input  logic              sdi_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo_data,
  output logic              sdo_en,
  output logic [CFG_W-1:0]  cfg_out,
  output logic              converting
);

  logic [N_SYNC-1:0] lvl;
  logic [N_EDGE-1:0] lvl_d;
  logic [N_SYNC-1:0] raw;
  logic              cnv_rise;
  logic              sck_rise;
  logic              sck_fall;
  logic              eoc;

  always_comb begin
    raw          = '0;
    raw[IDX_CNV] = cnv_in;
    raw[IDX_SCK] = sck_in;
    raw[IDX_SDI] = sdi_in;
  end

  adc_sp_sync #(.N(N_SYNC), .EDGE_N(N_EDGE)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (raw),
    .level    (lvl),
    .prev     (lvl_d)
  );

  assign cnv_rise = lvl[IDX_CNV] & ~lvl_d[IDX_CNV];
  assign sck_rise = lvl[IDX_SCK] & ~lvl_d[IDX_SCK];
  assign sck_fall = ~lvl[IDX_SCK] & lvl_d[IDX_SCK];

  adc_sp_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .start      (cnv_rise),
    .converting (converting),
    .eoc        (eoc)
  );

  adc_sp_cfg_rx #(.CFG_W(CFG_W), .CFG_RESET(CFG_RESET)) u_cfg (
    .clk        (clk),
    .rst        (rst),
    .eoc        (eoc),
    .converting (converting),
    .sck_rise   (sck_rise),
    .sdi        (lvl[IDX_SDI]),
    .cfg_q      (cfg_out)
  );

  adc_sp_data_tx #(.DATA_W(DATA_W)) u_tx (
    .clk        (clk),
    .rst        (rst),
    .eoc        (eoc),
    .converting (converting),
    .cnv_level  (lvl[IDX_CNV]),
    .sck_fall   (sck_fall),
    .sample     (sample_in),
    .sdo_data   (sdo_data),
    .sdo_en     (sdo_en)
  );

endmodule

// File: rtl/adc_sp_chk.sv
module adc_sp_chk #(
  parameter int unsigned CONV_CYCLES = 40,
  parameter int unsigned CFG_W       = 14
) (
  input logic             clk,
  input logic             rst,
  input logic             cnv_in,
  input logic             converting,
  input logic             sdo_en,
  input logic             sdo_data,
  input logic [CFG_W-1:0] cfg_out
);

  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst)             run_len <= 0;
    else if (converting) run_len <= run_len + 1;
    else                 run_len <= 0;
  end

  // R2
  conv_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(converting) |-> (run_len == CONV_CYCLES));

  // R2
  conv_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(converting) |-> $past(cnv_in, 3));

  // R6
  cnv_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cnv_in, 3) |-> !sdo_en);

  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (converting && $past(converting)) |-> $stable(cfg_out));

  // R9
  sdo_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(converting) && $past(converting, 2)) |-> $stable(sdo_data));

endmodule

bind adc_serial_port adc_sp_chk #(.CONV_CYCLES(CONV_CYCLES), .CFG_W(CFG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnv_in     (cnv_in),
  .converting (converting),
  .sdo_en     (sdo_en),
  .sdo_data   (sdo_data),
  .cfg_out    (cfg_out)
);

// File: tb/sim_adc_serial_port.sv
module sim_adc_serial_port;

  localparam int CLK_PERIOD = 10;
  localparam int CONV       = 40;
  localparam int HALF       = 6;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnv = 1'b0;
  logic        sck = 1'b0;
  logic        sdi = 1'b0;
  logic [15:0] sample = '0;
  logic        sdo_data, sdo_en, converting;
  logic [13:0] cfg_out;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  logic [13:0] cfg_exp = 14'h3FFF;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port #(.DATA_W(16), .CFG_W(14), .CONV_CYCLES(CONV)) u0 (
    .clk(clk), .rst(rst), .cnv_in(cnv), .sck_in(sck), .sdi_in(sdi),
    .sample_in(sample), .sdo_data(sdo_data), .sdo_en(sdo_en),
    .cfg_out(cfg_out), .converting(converting)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // one serial clock period: rising edge then falling edge
  task automatic pulse(input logic d);
    sdi = d;
    idle(2);
    sck = 1'b1;
    idle(HALF);
    sck = 1'b0;
    idle(HALF);
  endtask

  // start a conversion; busy: CNV low at end; retrig: extra CNV edge mid-conversion
  task automatic start_conv(input bit busy, input bit retrig);
    int len = 0;
    for (int i = 0; i < CONV + 20; i++) begin
      @(negedge clk);
      if (converting) len++;
      if (i == 0) cnv = 1'b1;
      if (i == 4 && busy) cnv = 1'b0;
      if (retrig && i == 8)  cnv = busy ? 1'b1 : 1'b0;
      if (retrig && i == 12) cnv = busy ? 1'b0 : 1'b1;
    end
    chk("R2", "conversion length", len, CONV);
    chk("R2", "converting after end", converting, 0);
  endtask

  task automatic read_word(input logic [15:0] exp, input bit busy,
                           input logic [13:0] cfgw, input int nfall);
    if (busy) begin
      chk("R3", "busy enable", sdo_en, 1);
      chk("R3", "busy level", sdo_data, 0);
    end else begin
      chk("R6", "release with CNV high", sdo_en, 0);
      cnv = 1'b0;
      idle(4);
      chk("R3", "armed stays released", sdo_en, 0);
    end
    for (int k = 0; k < nfall; k++) begin
      pulse(k < 14 ? cfgw[13-k] : 1'b1);
      if (k < 16) begin
        chk("R4", "bit enable", sdo_en, 1);
        chk("R4", "bit value", sdo_data, exp[15-k]);
      end else begin
        chk("R5", "released after 17th", sdo_en, 0);
      end
      if (k == 12) chk("R8", "cfg before 14th rise", cfg_out, cfg_exp);
      if (k == 13) begin
        cfg_exp = cfgw;
        chk("R8", "cfg at 14th rise", cfg_out, cfg_exp);
      end
    end
    if (nfall >= 17) chk("R8", "cfg after extra rises", cfg_out, cfg_exp);
    if (nfall == 16) begin
      idle(30);
      chk("R5", "LSB hold enable", sdo_en, 1);
      chk("R5", "LSB hold value", sdo_data, exp[0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    idle(5);
    rst = 1'b0;
    idle(3);
    chk("R1", "sdo_en", sdo_en, 0);
    chk("R1", "converting", converting, 0);
    chk("R1", "cfg reset", cfg_out, 14'h3FFF);

    // clocks before any conversion do nothing (R8)
    pulse(1'b0); pulse(1'b0);
    chk("R8", "cfg untouched before first conversion", cfg_out, 14'h3FFF);
    chk("R1", "still released", sdo_en, 0);

    // sweep of samples over both modes
    for (int s = 0; s < 10; s++) begin
      logic [15:0] v;
      logic [13:0] cw;
      bit bm;
      v  = (s == 0) ? 16'h0000 : (s == 1) ? 16'hFFFF : 16'(s * 16'h9E37 + 16'h1234);
      cw = 14'(s * 14'h1B5) ^ 14'h2AA;
      bm = (s % 2) == 0;
      sample = v;
      start_conv(bm, (s % 3) == 0);
      read_word(v, bm, cw, 17);
      pulse(1'b1);
      chk("R5", "extra falls stay released", sdo_en, 0);
    end

    // partial read, then next conversion in busy mode
    sample = 16'h8001;
    start_conv(1'b1, 1'b0);
    read_word(16'h8001, 1'b1, 14'h1234, 16);
    sample = 16'h4C3E;
    cnv = 1'b1;
    idle(4);
    chk("R6", "CNV high releases held bit", sdo_en, 0);
    cnv = 1'b0;
    idle(4);
    chk("R2", "conversion running", converting, 1);
    chk("R7", "held bit enable", sdo_en, 1);
    chk("R7", "held bit value", sdo_data, 1);
    pulse(1'b0);
    pulse(1'b1);
    chk("R9", "falls ignored enable", sdo_en, 1);
    chk("R9", "falls ignored value", sdo_data, 1);
    chk("R9", "rises ignored cfg", cfg_out, cfg_exp);
    while (converting) idle(1);
    idle(6);
    read_word(16'h4C3E, 1'b1, 14'h0F0F, 17);

    idle(10);
    finish_run();
  end

endmodule